// File: doc/BRIEF.md
# SPI Pin Sharing Port Controller

This block decides who owns the four pins of a serial peripheral interface: the SPI engine or software through a small general-purpose port. Software sees two 8-bit registers on a simple register bus, a port value register and a direction register. For each pin, the block chooses whether the output value and output enable come from the SPI engine or from those registers. It also composes what a read of the port value register returns.

Pin index 0 is the slave select, 1 is the serial clock, 2 is the master-out line and 3 is the master-in line. When the SPI enable input is high, the engine drives pins 0 to 2 and the master-in pin is held as an input. When the enable is low, all four pins follow the two registers. Pad input levels pass through a two-stage synchronizer before software can read them. Bits 7 to 4 of both registers are storage only and have no pins.

Top module: `spi_pin_port`

## Requirements
- R1: After synchronous reset, both registers hold 0x00. With SPI disabled, all four output enables are then low, and a read of either register returns 0x00 while the pads are low.
- R2: A write happens on a rising edge with `bus_wr` high. `bus_addr` 0 selects the port value register and 1 selects the direction register. A read at `bus_addr` 1 returns all 8 direction bits.
- R3: With SPI disabled, pin i has output enable equal to direction bit i. Its output is port bit i when that enable is high and 0 otherwise.
- R4: With SPI enabled, pins 0 to 2 take their output enable from `eng_oe`. Their output is `eng_out` when that enable is high and 0 otherwise.
- R5: With SPI enabled, pin 3 has its output enable low and its output at 0, whatever the registers hold.
- R6: At `bus_addr` 0, a bit i below 4 whose direction bit is 0 returns the pad level. The read reflects a pad change after the second rising edge following it, and not after the first.
- R7: At `bus_addr` 0, a bit i below 4 whose direction bit is 1 returns the driver input. That is `eng_out[i]` for pins 0 to 2 while SPI is enabled, and port bit i in every other case.
- R8: At `bus_addr` 0, bits 7 to 4 always read 0.
- R9: While SPI is enabled, writes to the port value register do not change pins 0 to 2. The written value drives the pins once SPI is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 port value, 1 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| spi_en | input | 1 | SPI enable; engine owns pins 0 to 2 |
| eng_out | input | 4 | Per-pin output value from the SPI engine |
| eng_oe | input | 4 | Per-pin output enable from the SPI engine |
| pad_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Per-pin output value |
| pin_oe | output | 4 | Per-pin output enable |

## Verification
A register write and an SPI ownership change can land in the same cycle. A port read can also see a pad edge at the same moment as a direction flip. In that case the result depends on whether the bit returns the synchronized pad or the driver input. Random stimulus toggles `spi_en`, direction bits, pads and writes together on most cycles. A bench model tracks the two registers and the two synchronizer stages, and every cycle it compares `pin_out`, `pin_oe` and `bus_rdata` against values derived from the requirements. Directed steps cover reset, the synchronizer latency, the zero upper nibble, and a port write made while the engine owns the pins.

// File: rtl/spip_pkg.sv
package spip_pkg;

    localparam int REG_W       = 8;
    localparam int PIN_N       = 4;
    localparam int SYNC_STAGES = 2;

    localparam int PIN_SEL  = 0;
    localparam int PIN_CLK  = 1;
    localparam int PIN_MOUT = 2;
    localparam int PIN_MIN  = 3;

    typedef enum logic {
        ADDR_PORT = 1'b0,
        ADDR_DIR  = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic drv;
        logic oe;
    } pin_drive_t;

    function automatic bit engine_owns(input int idx);
        return idx != PIN_MIN;
    endfunction

endpackage

// File: rtl/spip_regs.sv
module spip_regs
    import spip_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] port_q,
    output logic [W-1:0] dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            if (reg_addr_e'(addr) == ADDR_DIR) dir_q  <= wdata;
            else                               port_q <= wdata;
        end
    end

endmodule

// File: rtl/spip_sync.sv
module spip_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spip_pinmux.sv
module spip_pinmux
    import spip_pkg::*;
#(
    parameter int N = PIN_N
) (
    input  logic         spi_en,
    input  logic [N-1:0] port_bits,
    input  logic [N-1:0] dir_bits,
    input  logic [N-1:0] eng_out,
    input  logic [N-1:0] eng_oe,
    output logic [N-1:0] drv_val,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe
);

    pin_drive_t sel [N];

    for (genvar i = 0; i < N; i++) begin : g_pin
        if (engine_owns(i)) begin : g_eng
            always_comb begin
                sel[i].drv = spi_en ? eng_out[i] : port_bits[i];
                sel[i].oe  = spi_en ? eng_oe[i]  : dir_bits[i];
            end
        end else begin : g_in
            always_comb begin
                sel[i].drv = port_bits[i];
                sel[i].oe  = spi_en ? 1'b0 : dir_bits[i];
            end
        end
        assign drv_val[i] = sel[i].drv;
        assign pin_oe[i]  = sel[i].oe;
        assign pin_out[i] = sel[i].oe & sel[i].drv;
    end

endmodule

// File: rtl/spi_pin_port.sv
module spi_pin_port
    import spip_pkg::*;
#(
    parameter int RW     = REG_W,
    parameter int PN     = PIN_N,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [RW-1:0] bus_wdata,
    output logic [RW-1:0] bus_rdata,
    input  logic          spi_en,
    input  logic [PN-1:0] eng_out,
    input  logic [PN-1:0] eng_oe,
    input  logic [PN-1:0] pad_in,
    output logic [PN-1:0] pin_out,
    output logic [PN-1:0] pin_oe
);

    logic [RW-1:0] port_q, dir_q, port_view;
    logic [PN-1:0] pad_s, drv_val;

    spip_regs #(.W(RW)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .port_q(port_q), .dir_q(dir_q)
    );

    spip_sync #(.W(PN), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pad_s)
    );

    spip_pinmux #(.N(PN)) u_mux (
        .spi_en(spi_en), .port_bits(port_q[PN-1:0]), .dir_bits(dir_q[PN-1:0]),
        .eng_out(eng_out), .eng_oe(eng_oe),
        .drv_val(drv_val), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    for (genvar b = 0; b < RW; b++) begin : g_rd
        if (b < PN) begin : g_pin
            assign port_view[b] = dir_q[b] ? drv_val[b] : pad_s[b];
        end else begin : g_none
            assign port_view[b] = 1'b0;
        end
    end

    assign bus_rdata = (reg_addr_e'(bus_addr) == ADDR_DIR) ? dir_q : port_view;

endmodule

// File: rtl/spip_checker.sv
module spip_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       spi_en,
    input logic [3:0] eng_oe,
    input logic [3:0] pin_out,
    input logic [3:0] pin_oe
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !spi_en) |-> (pin_oe == 4'b0000));

    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr) && $past(bus_addr) && bus_addr)
        |-> (bus_rdata == $past(bus_wdata)));

    a_r3_no_drive_off: assert property (@(posedge clk) disable iff (rst)
        !spi_en |-> ((pin_out & ~pin_oe) == 4'b0000));

    a_r4_engine_oe: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> (pin_oe[2:0] == eng_oe[2:0]));

    a_r5_min_input: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> (!pin_oe[3] && !pin_out[3]));

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> (bus_rdata[7:4] == 4'b0000));

endmodule

bind spi_pin_port spip_checker u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .eng_oe(eng_oe), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_spi_pin_port.sv
`timescale 1ns/1ps
module sim_spi_pin_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_en = 1'b0;
    logic [3:0] eng_out = '0, eng_oe = '0, pad_in = '0;
    logic [3:0] pin_out, pin_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_port, m_dir;
    logic [3:0] m_s1, m_s2;

    always #10 clk = ~clk;

    spi_pin_port u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
        .eng_out(eng_out), .eng_oe(eng_oe), .pad_in(pad_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_port <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            if (bus_wr && bus_addr)  m_dir  <= bus_wdata;
            if (bus_wr && !bus_addr) m_port <= bus_wdata;
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    function automatic logic [3:0] f_oe(logic en, logic [3:0] dir, logic [3:0] eoe);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = en ? ((i < 3) ? eoe[i] : 1'b0) : dir[i];
        return r;
    endfunction

    function automatic logic [3:0] f_drv(logic en, logic [3:0] port, logic [3:0] eo);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = (en && i < 3) ? eo[i] : port[i];
        return r;
    endfunction

    function automatic logic [7:0] f_rd(logic a, logic en, logic [7:0] dir,
                                        logic [7:0] port, logic [3:0] eo, logic [3:0] s2);
        logic [3:0] d;
        logic [7:0] r;
        d = f_drv(en, port[3:0], eo);
        r = 8'h00;
        for (int i = 0; i < 4; i++) r[i] = dir[i] ? d[i] : s2[i];
        return a ? dir : r;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [3:0] eoe, edrv;
        eoe  = f_oe(spi_en, m_dir[3:0], eng_oe);
        edrv = f_drv(spi_en, m_port[3:0], eng_out);
        if (spi_en) begin
            chk("R4,R5 pin_oe", {4'h0, pin_oe}, {4'h0, eoe});
            chk("R4,R5 pin_out", {4'h0, pin_out}, {4'h0, edrv & eoe});
        end else begin
            chk("R3 pin_oe", {4'h0, pin_oe}, {4'h0, eoe});
            chk("R3 pin_out", {4'h0, pin_out}, {4'h0, edrv & eoe});
        end
        chk(bus_addr ? "R2 rdata" : "R6,R7,R8 rdata", bus_rdata,
            f_rd(bus_addr, spi_en, m_dir, m_port, eng_out, m_s2));
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 pin_oe", {4'h0, pin_oe}, 8'h00);
        bus_addr = 1'b1; #1;
        chk("R1 dir read", bus_rdata, 8'h00);
        bus_addr = 1'b0; #1;
        chk("R1 port read", bus_rdata, 8'h00);

        // R2: direction register holds all 8 bits
        wr(1'b1, 8'hA5);
        bus_addr = 1'b1; #1;
        chk("R2 dir readback", bus_rdata, 8'hA5);

        // R8 and R6: inputs with all-ones port, upper nibble zero
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        pad_in = 4'hF;
        bus_addr = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R8 upper zero", bus_rdata, 8'h0F);
        pad_in = 4'h0;
        @(negedge clk); #1;
        chk("R6 one edge", bus_rdata, 8'h0F);
        @(negedge clk); #1;
        chk("R6 two edges", bus_rdata, 8'h00);

        // R7: outputs read the driver input, not the pad
        wr(1'b1, 8'h0F);
        bus_addr = 1'b0; #1;
        chk("R7 gpio driver", bus_rdata, 8'h0F);

        // R9: port write under SPI does not reach engine pins
        spi_en = 1'b1; eng_out = 4'h5; eng_oe = 4'h7;
        wr(1'b0, 8'h00);
        #1;
        chk("R9 pins kept", {4'h0, pin_out}, 8'h05);
        chk("R5 min off", {7'h0, pin_oe[3]}, 8'h00);
        chk("R7 spi driver", bus_rdata, 8'h05);
        spi_en = 1'b0; #1;
        chk("R9 after release", {4'h0, pin_out}, 8'h00);
        chk("R9 oe after release", {4'h0, pin_oe}, 8'h0F);

        // random mix
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            spi_en    = ($urandom % 2) == 0;
            eng_out   = 4'($urandom);
            eng_oe    = 4'($urandom);
            pad_in    = 4'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 1'($urandom);
            bus_wdata = 8'($urandom);
            #1;
            check_all();
        end
        @(negedge clk);
        bus_wr = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule